// File: doc/BRIEF.md
# Sigma-Delta Sinc3 Decimation Filter

This block turns the single-bit output stream of a sigma-delta modulator into 16-bit two's-complement samples. It is clocked by the modulator's own clock. The data bit is taken either on the rising edge of that clock or, when the inversion select is set, on the falling edge. Each captured bit counts as +1 or -1. It passes through three cascaded integrators at the bit rate and three cascaded differentiators at one sixty-fourth of that rate. The raw result is scaled down so that a constant stream lands on a symmetric full scale of plus or minus 16384.

A one-cycle valid strobe marks each new sample, once every 64 enabled modulator clocks. The strobe is held back for the first three decimation periods after reset or enable, while the filter window is still filling. Dropping the enable clears the whole pipeline, and raising it again starts a fresh fill.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: With `clk_inv_i` = 0, `data_i` is taken on the rising edge of `clk_i`. A stream that is 1 at every rising edge and 0 at every falling edge gives `sample_o` = +16384.
- R2: With `clk_inv_i` = 1, `data_i` is taken on the falling edge of `clk_i`. The same rising-1/falling-0 stream gives `sample_o` = -16384, and a periodic pattern gives the same value as in rising-edge capture.
- R3: A constant stream of 1 bits gives exactly +16384 (0x4000) on every valid sample. A constant stream of 0 bits gives exactly -16384 (0xC000). Every valid sample lies within -16384..+16384.
- R4: A stream that repeats with period p (p divides 64) and holds k ones per period gives `sample_o` = 16384*(2k-p)/p on every valid sample.
- R5: `valid_o` is high for exactly one cycle, and successive pulses are exactly 64 enabled rising edges apart.
- R6: Counting rising edges of `clk_i` from the first one with `en_i` = 1, the first `valid_o` pulse follows rising edge 256, which is the fourth decimation boundary.
- R7: While `en_i` = 0, all filter state is cleared from the next rising edge on: `valid_o` = 0 and `sample_o` = 0.
- R8: `rst_ni` = 0 forces `sample_o` = 0 and `valid_o` = 0 at once, without waiting for a clock edge.
- R9: `sample_o` changes only on the edge that raises `valid_o` or on a clear. It stays 0 during the fill after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock; all filter logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the pipeline |
| clk_inv_i | input | 1 | 1 selects falling-edge capture of data_i |
| data_i | input | 1 | Modulator bit stream |
| sample_o | output | 16 | Filtered two's-complement sample |
| valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The first sample is due right after the 256th enabled rising edge, and each later one 64 edges after the previous. The bench counts enabled rising edges from the moment it raises the enable and samples the outputs 1 ns after each falling edge, so every check lands half a cycle after the edge that updates the registers. Stimulus bits change 2 ns after the edge they must not race: after the falling edge for rising-edge capture, and after the rising edge for falling-edge capture. The clear and reset checks are read at the first falling edge after the clear edge, or 1 ns after the reset falls.

// File: rtl/sdm_sinc3_pkg.sv
package sdm_sinc3_pkg;
  localparam int ORDER = 3;

  function automatic int acc_width(input int osr_log2);
    return ORDER * osr_log2 + 2;
  endfunction
endpackage

// File: rtl/sdm_edge_capture.sv
module sdm_edge_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inv_i,
  input  logic data_i,
  output logic bit_o
);
  logic fall_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= data_i;
  end

  // rising-edge path samples data_i directly at the consuming flop
  assign bit_o = inv_i ? fall_q : data_i;
endmodule

// File: rtl/sdm_integ_chain.sv
module sdm_integ_chain #(
  parameter int ACC_W = 20,
  parameter int ORDER = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q  [ORDER];
  logic [ACC_W-1:0] stg_in [ORDER];

  assign stg_in[0] = bit_i ? ACC_W'(1) : '1;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    if (s > 0) begin : g_link
      assign stg_in[s] = acc_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q[s] <= '0;
      else if (clr_i) acc_q[s] <= '0;
      else            acc_q[s] <= acc_q[s] + stg_in[s];
    end
  end

  assign acc_o = acc_q[ORDER-1];
endmodule

// File: rtl/sdm_decim_ctrl.sv
module sdm_decim_ctrl #(
  parameter int OSR   = 64,
  parameter int ORDER = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o,
  output logic fire_o,
  output logic valid_o
);
  localparam int CNT_W  = $clog2(OSR);
  localparam int FILL_W = $clog2(ORDER + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;
  logic              valid_q;
  logic              filled;

  assign filled = (fill_q == FILL_W'(ORDER));
  assign tick_o = !clr_i && (cnt_q == CNT_W'(OSR - 1));
  assign fire_o = tick_o && filled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fill_q  <= '0;
      valid_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      fill_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= tick_o ? '0 : cnt_q + 1'b1;
      if (tick_o && !filled) fill_q <= fill_q + 1'b1;
      valid_q <= fire_o;
    end
  end

  assign valid_o = valid_q;

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cnt_q == '0);

  p_fill_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> fill_q == FILL_W'(ORDER));
endmodule

// File: rtl/sdm_comb_chain.sv
module sdm_comb_chain #(
  parameter int ACC_W = 20,
  parameter int ORDER = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [ACC_W-1:0] diff_o
);
  logic [ACC_W-1:0] dly_q [ORDER];
  logic [ACC_W-1:0] c     [ORDER+1];

  assign c[0] = acc_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    assign c[s+1] = c[s] - dly_q[s];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q[s] <= '0;
      else if (clr_i)  dly_q[s] <= '0;
      else if (tick_i) dly_q[s] <= c[s];
    end
  end

  assign diff_o = c[ORDER];
endmodule

// File: rtl/sdm_sinc3_decim.sv
module sdm_sinc3_decim
  import sdm_sinc3_pkg::*;
#(
  parameter int OSR     = 64,
  parameter int OUT_W   = 16,
  parameter int FS_LOG2 = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clk_inv_i,
  input  logic             data_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int OSR_LOG2 = $clog2(OSR);
  localparam int ACC_W    = acc_width(OSR_LOG2);
  localparam int SHIFT    = ORDER * OSR_LOG2 - FS_LOG2;
  localparam int RAW_FS   = 1 << (ORDER * OSR_LOG2);
  localparam int OUT_FS   = 1 << FS_LOG2;

  logic             clr;
  logic             cap_bit;
  logic [ACC_W-1:0] integ;
  logic [ACC_W-1:0] diff;
  logic             tick;
  logic             fire;
  logic [OUT_W-1:0] sample_q;

  assign clr = !en_i;

  sdm_edge_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inv_i  (clk_inv_i),
    .data_i (data_i),
    .bit_o  (cap_bit)
  );

  sdm_integ_chain #(.ACC_W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .bit_i  (cap_bit),
    .acc_o  (integ)
  );

  sdm_decim_ctrl #(.OSR(OSR), .ORDER(ORDER)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_o  (tick),
    .fire_o  (fire),
    .valid_o (valid_o)
  );

  sdm_comb_chain #(.ACC_W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .acc_i  (integ),
    .diff_o (diff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sample_q <= '0;
    else if (clr)   sample_q <= '0;
    else if (fire)  sample_q <= diff[SHIFT +: OUT_W];
  end

  assign sample_o = sample_q;

  p_raw_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> ($signed(diff) <= RAW_FS && $signed(diff) >= -RAW_FS));

  p_out_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($signed(sample_o) <= OUT_FS && $signed(sample_o) >= -OUT_FS));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!valid_o && sample_o == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid_o) |-> $stable(sample_o));
endmodule

// File: tb/tb_sdm_sinc3_decim.sv
module tb_sdm_sinc3_decim;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        clk_inv_i = 1'b0;
  logic        data_i = 1'b0;
  logic [15:0] sample_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  sdm_sinc3_decim dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .clk_inv_i (clk_inv_i),
    .data_i    (data_i),
    .sample_o  (sample_o),
    .valid_o   (valid_o)
  );

  // mode 0: pattern, launched after falling edge; 1: pattern after rising edge;
  // 2: 1 at every rising edge, 0 at every falling edge
  typedef struct packed {
    logic [63:0] pat;
    logic [7:0]  per;
    logic        inv;
    logic [1:0]  mode;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64'h1,              8'd1,  1'b0, 2'd0},
    '{64'h0,              8'd1,  1'b0, 2'd0},
    '{64'h1,              8'd2,  1'b0, 2'd0},
    '{64'h7,              8'd4,  1'b0, 2'd0},
    '{64'h1,              8'd4,  1'b0, 2'd0},
    '{64'hFE,             8'd8,  1'b0, 2'd0},
    '{64'h001F,           8'd16, 1'b0, 2'd0},
    '{64'h1,              8'd64, 1'b0, 2'd0},
    '{64'h7,              8'd4,  1'b1, 2'd1},
    '{64'h0,              8'd1,  1'b0, 2'd2},
    '{64'h0,              8'd1,  1'b1, 2'd2}
  };

  logic [63:0] cur_pat = '0;
  int          cur_per = 1;
  int          cur_mode = 0;
  int          bidx = 0;

  task automatic drive_bit();
    data_i = cur_pat[bidx];
    bidx   = (bidx + 1 >= cur_per) ? 0 : bidx + 1;
  endtask

  always begin
    @(posedge clk_i); #2;
    if (cur_mode == 1) drive_bit();
    else if (cur_mode == 2) data_i = 1'b0;
    @(negedge clk_i); #2;
    if (cur_mode == 0) drive_bit();
    else if (cur_mode == 2) data_i = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_of(input vec_t v);
    int ones = 0;
    if (v.mode == 2) return v.inv ? -16384 : 16384;
    for (int i = 0; i < int'(v.per); i++) ones += int'(v.pat[i]);
    return (16384 / int'(v.per)) * (2 * ones - int'(v.per));
  endfunction

  function automatic string tag_of(input vec_t v);
    if (v.mode == 2) return v.inv ? "R2" : "R1";
    if (v.inv) return "R2";
    if (v.per == 1) return "R3";
    return "R4";
  endfunction

  task automatic run_vec(input vec_t v);
    int n = 0, nv = 0, first = 0, prev = 0, nz = 0;
    int exp = expect_of(v);
    string tg = tag_of(v);
    @(negedge clk_i);
    en_i = 1'b0;
    clk_inv_i = v.inv;
    cur_pat = v.pat;
    cur_per = int'(v.per);
    cur_mode = int'(v.mode);
    bidx = 0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    while (nv < 3 && n < 600) begin
      @(posedge clk_i); n++;
      @(negedge clk_i); #1;
      if (valid_o) begin
        check(tg, int'($signed(sample_o)), exp);
        if (nv == 0) first = n;
        else check("R5", n - prev, 64);
        prev = n;
        nv++;
      end else if (nv == 0 && sample_o != 16'h0) nz = 1;
    end
    check("R6", first, 256);
    check("R9", nz, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    #1;
    check("R8", int'(sample_o), 0);
    check("R8", int'(valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // disable clears output and strobe
    @(negedge clk_i);
    en_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i); #1;
    check("R7", int'(sample_o), 0);
    check("R7", int'(valid_o), 0);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_i); #1;
      if (valid_o) cnt++;
    end
    check("R7", cnt, 0);

    // asynchronous reset mid-run, after a nonzero sample
    run_vec(VECS[0]);
    @(negedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    check("R8", int'(sample_o), 0);
    check("R8", int'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_vec(VECS[1]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule